// File: doc/BRIEF.md
# External Trigger Exposure Controller

This block runs a single externally triggered exposure for an image sensor timing generator. It sits beside the line and frame counters of that generator and watches a trigger input and an end-of-exposure strobe. When a trigger edge is seen, it arms and then enters trigger mode on the next line sync or on the next frame sync. Which of the two applies is set by a two-bit shutter-kind input. While in trigger mode it raises a busy flag and forces the rest of the chip to normal-rate readout. It counts lines or frames against an exposure length supplied from outside. It then requests one readout pulse and returns to free-running operation.

Both slow inputs are sampled once per line, at a fixed pixel-clock offset after each line sync. A falling strobe edge can end the exposure early, and only one such edge is honoured per trigger. In the line-count mode, a burst of vertical transfer cycles can flush leftover charge right after entry. The readout request is held back until that burst has finished. Illegal events are dropped and set a sticky error flag: a second trigger, a second strobe edge, or an exposure length that the chosen mode cannot use.

Top module: `trig_expo_ctrl`

## Requirements
- R1: `trig_in` and `strobe_in` are sampled only on the single clock edge that comes SAMPLE_OFS+1 clocks after a `line_sync` edge. Level changes that start and end between two sample points have no effect. A sampled 0-to-1 change of `trig_in` is a trigger edge.
- R2: With `mode_sel` = 2'b01 (line-count mode), a trigger edge in idle arms the controller. `busy` rises in the cycle after the next `line_sync` edge. `readout_req` rises in the cycle after the N-th later `line_sync` edge, where N is `expo_len`. N must be at least 1.
- R3: With `mode_sel` = 2'b10 (frame-count mode), `busy` rises in the cycle after the next `frame_sync` edge, and that entry frame sync is not counted. `readout_req` rises after the N-th later `frame_sync` edge. N must be at least 3; a smaller value rejects the trigger and sets `err_flag`.
- R4: With `mode_sel` = 2'b00 or 2'b11, trigger edges are ignored. `busy` and `force_normal` stay low, and `err_flag` is not set.
- R5: `busy` is high from entry through the readout cycle. `readout_req` lasts exactly one cycle, always while `busy` is high, and `busy` is low in the following cycle.
- R6: `force_normal` is high from arming until `busy` falls, and therefore whenever `busy` is high.
- R7: In line-count mode, with `drain_en` high at the trigger, `drain_req` is high for exactly DRAIN_LEN consecutive cycles, starting in the cycle `busy` rises. In frame-count mode, or with `drain_en` low, `drain_req` stays low.
- R8: `readout_req` never overlaps `drain_req`. If the exposure ends while the burst is running, `readout_req` rises in the cycle right after the last `drain_req` cycle.
- R9: In trigger mode, with `strobe_hold` low, the first sampled 1-to-0 change of `strobe_in` ends the exposure. `readout_req` then rises SAMPLE_OFS+2 clock edges after the `line_sync` edge that opened that line. With `strobe_hold` high, the strobe does not change when readout happens.
- R10: A trigger edge while not idle, or a second strobe fall within one trigger, is dropped and sets `err_flag`. `err_flag` stays set until reset. The dropped event does not move the readout.
- R11: While `rst` is high at a clock edge, the controller returns to idle. `busy`, `readout_req`, `drain_req`, `force_normal` and `err_flag` are all low after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| line_sync | input | 1 | One-cycle line sync event |
| frame_sync | input | 1 | One-cycle frame sync event |
| trig_in | input | 1 | Trigger input, idle high, armed on sampled rise |
| strobe_in | input | 1 | End-of-exposure strobe, idle high, acts on sampled fall |
| mode_sel | input | 2 | Shutter kind: 01 line count, 10 frame count, others off |
| drain_en | input | 1 | Enable vertical flush burst in line-count mode |
| strobe_hold | input | 1 | High: strobe does not end exposure |
| expo_len | input | CNT_W | Exposure length in lines or frames |
| busy | output | 1 | Trigger mode active |
| readout_req | output | 1 | One-cycle readout pulse request |
| drain_req | output | 1 | Vertical flush burst request |
| force_normal | output | 1 | Force normal-rate readout |
| err_flag | output | 1 | Sticky illegal-event flag |

## Verification
The assertions check the output relations on every cycle. Readout only happens inside busy, lasts one cycle and is followed by busy low. The flush burst never overlaps readout and starts together with busy. Busy implies force-normal, entry only follows a sync edge, and the error flag never clears by itself. Only the bench scenarios can show the counted behaviour. That covers the exact number of lines or frames between entry and readout, the strobe ending exposure at the sample point of its line, and the burst length and deferred readout. It also covers a glitch between sample points being ignored, the off modes, and rejection of a too-short frame count.

// File: rtl/trig_expo_pkg.sv
package trig_expo_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM_LN,
        ST_ARM_FR,
        ST_EXPO,
        ST_DRAIN,
        ST_READ
    } ctl_state_e;

    typedef enum logic [1:0] {
        SH_OFF,
        SH_LINE,
        SH_FRAME
    } shut_kind_e;

    typedef struct packed {
        shut_kind_e kind;
        logic       drain;
        logic       hold;
    } trig_cfg_t;

    localparam int MIN_FRAMES = 3;

    function automatic shut_kind_e decode_shut(input logic [1:0] sel);
        shut_kind_e k;
        case (sel)
            2'b01:   k = SH_LINE;
            2'b10:   k = SH_FRAME;
            default: k = SH_OFF;
        endcase
        return k;
    endfunction

    function automatic logic is_busy_state(input ctl_state_e s);
        return (s == ST_EXPO) || (s == ST_DRAIN) || (s == ST_READ);
    endfunction

endpackage

// File: rtl/trig_samp.sv
module trig_samp #(
    parameter int SAMPLE_OFS = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic line_sync,
    input  logic trig_in,
    input  logic strobe_in,
    output logic trig_rise,
    output logic strobe_fall
);
    localparam int OFS_W = $clog2(SAMPLE_OFS + 1) < 1 ? 1 : $clog2(SAMPLE_OFS + 1);

    logic [OFS_W-1:0] pos;
    logic             run;
    logic             trig_q;
    logic             strobe_q;
    logic             samp_pt;

    assign samp_pt = run && (pos == OFS_W'(SAMPLE_OFS));

    always_ff @(posedge clk) begin
        if (rst) begin
            pos         <= '0;
            run         <= 1'b0;
            trig_q      <= 1'b1;
            strobe_q    <= 1'b1;
            trig_rise   <= 1'b0;
            strobe_fall <= 1'b0;
        end else begin
            trig_rise   <= 1'b0;
            strobe_fall <= 1'b0;
            if (line_sync) begin
                pos <= '0;
                run <= 1'b1;
            end else if (samp_pt) begin
                run <= 1'b0;
            end else if (run) begin
                pos <= pos + 1'b1;
            end
            if (samp_pt) begin
                trig_q      <= trig_in;
                strobe_q    <= strobe_in;
                trig_rise   <= trig_in & ~trig_q;
                strobe_fall <= ~strobe_in & strobe_q;
            end
        end
    end
endmodule

// File: rtl/trig_evcnt.sv
module trig_evcnt #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             tick,
    input  logic [CNT_W-1:0] target,
    output logic             hit
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   nxt;

    assign nxt = {1'b0, cnt} + 1'b1;
    assign hit = tick && !clear && (nxt == {1'b0, target});

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= nxt[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/trig_drain.sv
module trig_drain #(
    parameter int DRAIN_LEN = 1045
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic active,
    output logic last
);
    localparam int DW = $clog2(DRAIN_LEN + 1);

    logic [DW-1:0] cnt;

    assign active = (cnt != '0);
    assign last   = (cnt <= DW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= DW'(DRAIN_LEN);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/trig_expo_ctrl.sv
module trig_expo_ctrl
    import trig_expo_pkg::*;
#(
    parameter int SAMPLE_OFS = 64,
    parameter int CNT_W      = 11,
    parameter int DRAIN_LEN  = 1045
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_sync,
    input  logic             frame_sync,
    input  logic             trig_in,
    input  logic             strobe_in,
    input  logic [1:0]       mode_sel,
    input  logic             drain_en,
    input  logic             strobe_hold,
    input  logic [CNT_W-1:0] expo_len,
    output logic             busy,
    output logic             readout_req,
    output logic             drain_req,
    output logic             force_normal,
    output logic             err_flag
);
    ctl_state_e       state;
    trig_cfg_t        cfg;
    logic [CNT_W-1:0] target;
    logic             strobe_used;
    logic             err_q;

    logic             trig_rise;
    logic             strobe_fall;
    logic             cnt_tick;
    logic             cnt_clear;
    logic             cnt_hit;
    logic             drain_start;
    logic             drain_active;
    logic             drain_last;
    logic             strobe_end;
    logic             end_now;
    shut_kind_e       req_kind;
    logic             len_ok;

    trig_samp #(.SAMPLE_OFS(SAMPLE_OFS)) u_samp (
        .clk        (clk),
        .rst        (rst),
        .line_sync  (line_sync),
        .trig_in    (trig_in),
        .strobe_in  (strobe_in),
        .trig_rise  (trig_rise),
        .strobe_fall(strobe_fall)
    );

    assign cnt_clear = (state != ST_EXPO);
    assign cnt_tick  = (cfg.kind == SH_LINE) ? line_sync : frame_sync;

    trig_evcnt #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clear (cnt_clear),
        .tick  (cnt_tick),
        .target(target),
        .hit   (cnt_hit)
    );

    assign drain_start = (state == ST_ARM_LN) && line_sync && cfg.drain;

    trig_drain #(.DRAIN_LEN(DRAIN_LEN)) u_drain (
        .clk   (clk),
        .rst   (rst),
        .start (drain_start),
        .active(drain_active),
        .last  (drain_last)
    );

    assign req_kind   = decode_shut(mode_sel);
    assign len_ok     = (req_kind == SH_LINE)  ? (expo_len != '0) :
                        (req_kind == SH_FRAME) ? (expo_len >= CNT_W'(MIN_FRAMES)) : 1'b0;
    assign strobe_end = strobe_fall && !strobe_used && !cfg.hold && (state == ST_EXPO);
    assign end_now    = cnt_hit || strobe_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            cfg         <= '{kind: SH_OFF, drain: 1'b0, hold: 1'b0};
            target      <= '0;
            strobe_used <= 1'b0;
            err_q       <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    strobe_used <= 1'b0;
                    if (trig_rise && req_kind != SH_OFF) begin
                        if (len_ok) begin
                            cfg.kind  <= req_kind;
                            cfg.drain <= drain_en && (req_kind == SH_LINE);
                            cfg.hold  <= strobe_hold;
                            target    <= expo_len;
                            state     <= (req_kind == SH_LINE) ? ST_ARM_LN : ST_ARM_FR;
                        end else begin
                            err_q <= 1'b1;
                        end
                    end
                end
                ST_ARM_LN: begin
                    if (line_sync) state <= ST_EXPO;
                end
                ST_ARM_FR: begin
                    if (frame_sync) state <= ST_EXPO;
                end
                ST_EXPO: begin
                    if (end_now) state <= drain_last ? ST_READ : ST_DRAIN;
                end
                ST_DRAIN: begin
                    if (drain_last) state <= ST_READ;
                end
                ST_READ: begin
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase

            if (trig_rise && state != ST_IDLE) begin
                err_q <= 1'b1;
            end
            if (strobe_fall && is_busy_state(state)) begin
                if (strobe_used) err_q <= 1'b1;
                else             strobe_used <= 1'b1;
            end
        end
    end

    assign busy         = is_busy_state(state);
    assign readout_req  = (state == ST_READ);
    assign drain_req    = drain_active;
    assign force_normal = (state != ST_IDLE);
    assign err_flag     = err_q;

endmodule

// File: rtl/trig_expo_chk.sv
module trig_expo_chk (
    input logic clk,
    input logic rst,
    input logic line_sync,
    input logic frame_sync,
    input logic busy,
    input logic readout_req,
    input logic drain_req,
    input logic force_normal,
    input logic err_flag
);
    p_ro_in_busy_r5: assert property (@(posedge clk) disable iff (rst)
        readout_req |-> busy);

    p_ro_single_r5: assert property (@(posedge clk) disable iff (rst)
        readout_req |=> (!readout_req && !busy));

    p_fn_cover_r6: assert property (@(posedge clk) disable iff (rst)
        busy |-> force_normal);

    p_drain_in_busy_r7: assert property (@(posedge clk) disable iff (rst)
        drain_req |-> busy);

    p_drain_start_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(drain_req) |-> $rose(busy));

    p_no_overlap_r8: assert property (@(posedge clk) disable iff (rst)
        readout_req |-> !drain_req);

    p_entry_sync_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(line_sync) || $past(frame_sync)));

    p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        err_flag |=> err_flag);
endmodule

bind trig_expo_ctrl trig_expo_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .line_sync   (line_sync),
    .frame_sync  (frame_sync),
    .busy        (busy),
    .readout_req (readout_req),
    .drain_req   (drain_req),
    .force_normal(force_normal),
    .err_flag    (err_flag)
);

// File: tb/sim_trig_expo_ctrl.sv
`timescale 1ns/1ps
module sim_trig_expo_ctrl;
    localparam int SAMPLE_OFS  = 5;
    localparam int CNT_W       = 8;
    localparam int DRAIN_LEN   = 40;
    localparam int LINE_LEN    = 16;
    localparam int FRAME_LINES = 6;
    localparam int LIMIT       = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line_sync = 1'b0, frame_sync = 1'b0;
    logic trig_in = 1'b1, strobe_in = 1'b1;
    logic [1:0] mode_sel = 2'b00;
    logic drain_en = 1'b0, strobe_hold = 1'b0;
    logic [CNT_W-1:0] expo_len = '0;
    logic busy, readout_req, drain_req, force_normal, err_flag;

    always #5 clk = ~clk;

    trig_expo_ctrl #(.SAMPLE_OFS(SAMPLE_OFS), .CNT_W(CNT_W), .DRAIN_LEN(DRAIN_LEN)) u0 (
        .clk(clk), .rst(rst), .line_sync(line_sync), .frame_sync(frame_sync),
        .trig_in(trig_in), .strobe_in(strobe_in), .mode_sel(mode_sel),
        .drain_en(drain_en), .strobe_hold(strobe_hold), .expo_len(expo_len),
        .busy(busy), .readout_req(readout_req), .drain_req(drain_req),
        .force_normal(force_normal), .err_flag(err_flag)
    );

    int checks = 0, errors = 0;
    bit done = 0;

    // sync generator (drives on negedge)
    int gen_pos = 0, gen_line = 0;
    always @(negedge clk) begin
        line_sync  <= (gen_pos == 0);
        frame_sync <= (gen_pos == 0) && (gen_line == 0);
        if (gen_pos == LINE_LEN - 1) begin
            gen_pos  <= 0;
            gen_line <= (gen_line == FRAME_LINES - 1) ? 0 : gen_line + 1;
        end else begin
            gen_pos <= gen_pos + 1;
        end
    end

    // edge bookkeeping
    int cyc = 0, lines = 0, frames = 0, ls_cyc = -100, fs_cyc = -100;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (line_sync)  begin lines  <= lines + 1;  ls_cyc <= cyc; end
        if (frame_sync) begin frames <= frames + 1; fs_cyc <= cyc; end
    end

    // output monitor
    int n_entries = 0, ent_lines = 0, ent_frames = 0, ent_dis = 0;
    bit ent_ls_ok = 0, ent_fs_ok = 0;
    int dis_total = 0, last_dis_cyc = -100, bad_dis = 0, bad_fn = 0, fn_cycles = 0;
    int rd_n = 0, rd_dl = 0, rd_df = 0, rd_rel = 0;
    bit rd_lastdis_ok = 0, rd_dis_on = 0, rd_prev = 0, busy_after_rd = 0, busy_prev = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (busy && !busy_prev) begin
                n_entries++;
                ent_lines  = lines;
                ent_frames = frames;
                ent_dis    = dis_total;
                ent_ls_ok  = (ls_cyc == cyc - 1);
                ent_fs_ok  = (fs_cyc == cyc - 1);
            end
            if (rd_prev) busy_after_rd = busy;
            if (force_normal) fn_cycles++;
            if (busy && !force_normal) bad_fn++;
            if (drain_req && !busy) bad_dis++;
            if (readout_req) begin
                rd_n++;
                rd_dl = lines - ent_lines;
                rd_df = frames - ent_frames;
                rd_rel = cyc - ls_cyc;
                rd_lastdis_ok = (last_dis_cyc == cyc - 1);
                rd_dis_on = drain_req;
            end
            if (drain_req) begin dis_total++; last_dis_cyc = cyc; end
            rd_prev = readout_req;
        end
        busy_prev = busy;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_line();
        int l0 = lines;
        while (lines == l0) @(negedge clk);
    endtask

    task automatic setup(input logic [1:0] m, input int n, input bit d, input bit h);
        mode_sel = m; expo_len = CNT_W'(n); drain_en = d; strobe_hold = h;
    endtask

    task automatic fire_trig();
        wait_line();
        trig_in = 1'b0;
        repeat (2 * LINE_LEN) @(negedge clk);
        trig_in = 1'b1;
    endtask

    task automatic pulse_strobe();
        strobe_in = 1'b0;
        repeat (2 * LINE_LEN) @(negedge clk);
        strobe_in = 1'b1;
    endtask

    task automatic wait_entry(input int n0, output bit got);
        got = 0;
        for (int i = 0; i < 2000; i++) begin
            if (n_entries != n0) begin got = 1; break; end
            @(negedge clk);
        end
    endtask

    task automatic wait_done(input int r0, output bit got);
        got = 0;
        for (int i = 0; i < 3000; i++) begin
            if (rd_n != r0) begin got = 1; break; end
            @(negedge clk);
        end
        repeat (2) @(negedge clk);
    endtask

    function automatic bit deferred(input bit is_line, input bit d, input int n);
        return is_line && d && (n * LINE_LEN < DRAIN_LEN);
    endfunction

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // watchdog
    always @(posedge clk) begin
        if (cyc > LIMIT && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, LIMIT);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit got;
        int r0, n0, f0, e0, d0;
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        // R11 reset state
        chk(!busy && !readout_req && !drain_req && !force_normal && !err_flag, "R11 reset outputs", {busy, readout_req, drain_req, force_normal, err_flag}, 0);
        rst = 1'b0;
        repeat (3) wait_line();

        // R1 glitch between sample points ignored
        setup(2'b01, 2, 0, 0);
        n0 = n_entries; f0 = fn_cycles;
        wait_line();
        repeat (SAMPLE_OFS + 2) @(negedge clk);
        trig_in = 1'b0;
        repeat (4) @(negedge clk);
        trig_in = 1'b1;
        repeat (4 * LINE_LEN) @(negedge clk);
        chk(n_entries == n0 && fn_cycles == f0, "R1 glitch ignored", n_entries - n0, 0);

        // R4 off modes
        setup(2'b00, 3, 0, 0);
        fire_trig();
        repeat (2 * FRAME_LINES * LINE_LEN) @(negedge clk);
        chk(n_entries == n0 && fn_cycles == f0 && !err_flag, "R4 mode 00 ignored", n_entries - n0, 0);
        setup(2'b11, 3, 0, 0);
        fire_trig();
        repeat (2 * FRAME_LINES * LINE_LEN) @(negedge clk);
        chk(n_entries == n0 && fn_cycles == f0 && !err_flag, "R4 mode 11 ignored", fn_cycles - f0, 0);

        // R2 line mode
        setup(2'b01, 3, 0, 0);
        r0 = rd_n;
        fire_trig();
        wait_done(r0, got);
        chk(got && ent_ls_ok, "R2 entry after line sync", ent_ls_ok, 1);
        chk(rd_dl == 3, "R2 lines to readout", rd_dl, 3);
        chk(!busy_after_rd && !busy, "R5 busy low after readout", busy_after_rd, 0);
        chk(bad_fn == 0 && !force_normal, "R6 force normal covers busy", bad_fn, 0);

        // R3 frame mode
        setup(2'b10, 3, 0, 0);
        r0 = rd_n;
        fire_trig();
        wait_done(r0, got);
        chk(got && ent_fs_ok, "R3 entry after frame sync", ent_fs_ok, 1);
        chk(rd_df == 3, "R3 frames to readout", rd_df, 3);

        // R3 frame count too small, then R11 reset clears error
        setup(2'b10, 2, 0, 0);
        n0 = n_entries;
        fire_trig();
        repeat (2 * FRAME_LINES * LINE_LEN) @(negedge clk);
        chk(n_entries == n0 && err_flag, "R3 short frame count rejected", err_flag, 1);
        do_reset();
        chk(!err_flag && !busy, "R11 reset clears error", err_flag, 0);

        // R7 drain burst, no deferral
        setup(2'b01, 5, 1, 0);
        r0 = rd_n;
        fire_trig();
        wait_done(r0, got);
        chk(got && dis_total - ent_dis == DRAIN_LEN, "R7 burst length", dis_total - ent_dis, DRAIN_LEN);
        chk(rd_dl == 5 && !rd_dis_on, "R7 lines with burst", rd_dl, 5);

        // R7 no burst in frame mode
        setup(2'b10, 3, 1, 0);
        r0 = rd_n; d0 = dis_total;
        fire_trig();
        wait_done(r0, got);
        chk(got && dis_total == d0, "R7 no burst frame mode", dis_total - d0, 0);

        // R8 deferral
        setup(2'b01, 1, 1, 0);
        r0 = rd_n;
        fire_trig();
        wait_done(r0, got);
        chk(got && rd_lastdis_ok && !rd_dis_on, "R8 readout right after burst", rd_lastdis_ok, 1);
        chk(dis_total - ent_dis == DRAIN_LEN, "R8 burst full length", dis_total - ent_dis, DRAIN_LEN);

        // R9 strobe ends exposure early
        setup(2'b01, 6, 0, 0);
        r0 = rd_n; n0 = n_entries;
        fire_trig();
        wait_entry(n0, got);
        @(negedge clk);
        pulse_strobe();
        wait_done(r0, got);
        chk(got && rd_dl < 6, "R9 early readout by strobe", rd_dl, 1);
        chk(rd_rel == SAMPLE_OFS + 3, "R9 strobe readout timing", rd_rel, SAMPLE_OFS + 3);
        chk(!err_flag, "R9 single strobe no error", err_flag, 0);

        // R9/R10 strobe held off, second strobe is an error
        setup(2'b01, 8, 0, 1);
        r0 = rd_n; n0 = n_entries;
        fire_trig();
        wait_entry(n0, got);
        @(negedge clk);
        pulse_strobe();
        repeat (2 * LINE_LEN) @(negedge clk);
        pulse_strobe();
        wait_done(r0, got);
        chk(got && rd_dl == 8, "R9 hold keeps count timing", rd_dl, 8);
        chk(err_flag, "R10 second strobe flagged", err_flag, 1);
        do_reset();

        // R10 trigger while busy
        setup(2'b01, 6, 0, 0);
        r0 = rd_n; n0 = n_entries;
        fire_trig();
        wait_entry(n0, got);
        fire_trig();
        wait_done(r0, got);
        chk(got && rd_dl == 6, "R10 dropped trigger keeps readout", rd_dl, 6);
        chk(err_flag, "R10 trigger while busy flagged", err_flag, 1);
        chk(n_entries == n0 + 1, "R10 no extra entry", n_entries - n0, 1);
        do_reset();

        // random mix
        for (int k = 0; k < 8; k++) begin
            bit is_line = ($urandom % 2) == 0;
            int n = is_line ? 1 + ($urandom % 4) : 3 + ($urandom % 2);
            bit d = $urandom % 2;
            setup(is_line ? 2'b01 : 2'b10, n, d, 1);
            r0 = rd_n; d0 = dis_total;
            fire_trig();
            wait_done(r0, got);
            chk(got, "R5 random readout seen", got, 1);
            if (deferred(is_line, d, n))
                chk(rd_lastdis_ok, "R8 random deferral", rd_lastdis_ok, 1);
            else if (is_line)
                chk(rd_dl == n, "R2 random lines", rd_dl, n);
            else
                chk(rd_df == n, "R3 random frames", rd_df, n);
            chk((dis_total - d0) == ((is_line && d) ? DRAIN_LEN : 0), "R7 random burst", dis_total - d0, (is_line && d) ? DRAIN_LEN : 0);
        end
        chk(bad_dis == 0, "R7 burst only inside busy", bad_dis, 0);
        chk(bad_fn == 0, "R6 force normal whole run", bad_fn, 0);
        e0 = 0;
        chk(!err_flag, "R10 no error on legal runs", err_flag, e0);

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule